// File: doc/BRIEF.md
# Nonvolatile Memory Control Register

This block is the 8-bit control and status register that software uses to drive on-chip nonvolatile storage. A single register byte selects the target space: data EEPROM, program flash or configuration space. Software starts a one-cycle read or a self-timed erase or write by writing to it, and reads back the progress and any error. Behind the register, a small sequencer raises a request to a behavioural storage array and waits for its done pulse. The array answers after a programmable number of clock cycles.

The start bits can only be set by software; hardware clears them. Two reset inputs exist. Power-on reset is asynchronous and clears everything. Warm reset is sampled on the clock and clears the enables and start bits. If a self-timed cycle is running when warm reset arrives, warm reset records an error flag and keeps the space selection, so software can still see which target was aborted. A one-cycle completion pulse marks every cycle that finishes normally, and can feed an interrupt flag.

Register bits, from 7 down to 0: flash select (1 = program flash, 0 = data EEPROM), configuration select, constant 0, row erase, write error, write enable, write start, read start.

Top module: `nvmCtrlReg`

## Requirements
- R1: Bit 5 always reads 0, and writing 1 to it changes nothing.
- R2: Writing 1 to bit 1 while bit 2 already reads 1 and no cycle is running starts a self-timed cycle. Bit 1 then reads 1 for exactly BUSY_CYCLES cycles, starting in the cycle after the write. Writing 0 to bit 1 during the cycle does not clear it.
- R3: Writing 1 to bit 0 while bit 7 reads 0 and no cycle is running sets bit 0 for exactly one cycle, with readStrobe high in that cycle. Hardware then clears bit 0.
- R4: Writing 1 to bit 0 while bit 7 already reads 1 is ignored: bit 0 and readStrobe stay 0.
- R5: Writing 1 to bit 1 while bit 2 reads 0 launches nothing: bit 1 and memReq stay 0.
- R6: If the launching write has bit 4 set, the cycle is an erase (memErase = 1), and bit 4 reads 0 after the cycle completes. Without bit 4 set, memErase is 0.
- R7: A warm reset during a running cycle sets bit 3. It keeps bits 7 and 6, clears bits 4, 2, 1 and 0, and drops memReq.
- R8: A cycle that completes normally clears bit 3.
- R9: Power-on reset clears the whole register at once, without waiting for a clock edge. A warm reset while idle keeps bits 7, 6 and 3.
- R10: While a cycle runs, writes do not change bits 7, 6 or 4. memSpace shows bits 7..6 as they stood at launch.
- R11: cycleDone is high for one cycle, in the first cycle in which bit 1 reads 0 after a normal completion. A cycle aborted by warm reset gives no cycleDone.
- R12: Software writes to bit 3 have no effect.
- R13: memReq is high for exactly the cycles in which bit 1 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| warmRstN | input | 1 | Warm reset, active low, sampled on clk |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Current register value |
| readStrobe | output | 1 | One-cycle read request to the storage |
| memReq | output | 1 | Self-timed cycle in progress |
| memErase | output | 1 | Current cycle is a row erase |
| memSpace | output | 2 | Space selection captured at launch |
| cycleDone | output | 1 | One-cycle pulse after normal completion |

## Verification
The bench builds the block with BUSY_CYCLES set to 5. With a cycle this short, a mid-cycle write, an abort two cycles after launch, and the exact busy count of R2 and R13 all fit in a few cycles each. The same short cycle lets the bench confirm, within a small window, that an aborted cycle never produces cycleDone.

// File: rtl/nvmCtrlPkg.sv
package nvmCtrlPkg;

  localparam int BIT_FLASH = 7;
  localparam int BIT_CFG   = 6;
  localparam int BIT_ZERO  = 5;
  localparam int BIT_ERASE = 4;
  localparam int BIT_ERR   = 3;
  localparam int BIT_WREN  = 2;
  localparam int BIT_WR    = 1;
  localparam int BIT_RD    = 0;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seqState_e;

  typedef struct packed {
    logic setWr;
    logic setRd;
    logic clrRd;
    logic finish;
    logic lockSpace;
  } nvmStrobe_t;

endpackage

// File: rtl/nvmArrayModel.sv
module nvmArrayModel #(
  parameter int BUSY_CYCLES = 16
) (
  input  logic clk,
  input  logic porN,
  input  logic warmRstN,
  input  logic memReq,
  output logic memDone
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      busyCnt <= '0;
    end else if (!warmRstN || !memReq) begin
      busyCnt <= '0;
    end else if (busyCnt != LAST + 1'b1) begin
      busyCnt <= busyCnt + 1'b1;
    end
  end

  assign memDone = memReq && (busyCnt == LAST);

  // R13
  req_held_chk: assert property (@(posedge clk) disable iff (!porN)
    (warmRstN && memReq && !memDone) |=> memReq);

endmodule

// File: rtl/nvmCtrlSeq.sv
module nvmCtrlSeq
  import nvmCtrlPkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       warmRstN,
  input  logic       regWrEn,
  input  logic       wrStartReq,
  input  logic       rdStartReq,
  input  logic       spaceFlashQ,
  input  logic       wrEnableQ,
  input  logic       wrStartQ,
  input  logic       rdStartQ,
  input  logic       memDone,
  output nvmStrobe_t strobe,
  output logic       memReq,
  output logic       cycleDone
);

  seqState_e state;
  logic      launchOk;
  logic      doneQ;

  always_comb begin
    launchOk = regWrEn && wrStartReq && wrEnableQ && !wrStartQ && (state == SEQ_IDLE);
    strobe           = '0;
    strobe.lockSpace = wrStartQ;
    strobe.setWr     = launchOk;
    strobe.setRd     = regWrEn && rdStartReq && !spaceFlashQ && !rdStartQ
                       && !wrStartQ && !launchOk;
    strobe.clrRd     = rdStartQ;
    strobe.finish    = (state == SEQ_BUSY) && memDone;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state <= SEQ_IDLE;
      doneQ <= 1'b0;
    end else if (!warmRstN) begin
      state <= SEQ_IDLE;
      doneQ <= 1'b0;
    end else begin
      doneQ <= strobe.finish;
      case (state)
        SEQ_IDLE: if (launchOk) state <= SEQ_BUSY;
        SEQ_BUSY: if (memDone)  state <= SEQ_IDLE;
        default:                state <= SEQ_IDLE;
      endcase
    end
  end

  assign memReq    = (state == SEQ_BUSY);
  assign cycleDone = doneQ;

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!porN)
    cycleDone |=> !cycleDone);

  // R13
  busy_visible_chk: assert property (@(posedge clk) disable iff (!porN)
    (state == SEQ_BUSY) |-> wrStartQ);

endmodule

// File: rtl/nvmCtrlRegfile.sv
module nvmCtrlRegfile
  import nvmCtrlPkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       warmRstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  nvmStrobe_t strobe,
  output logic [7:0] regRdData,
  output logic       spaceFlashQ,
  output logic       wrEnableQ,
  output logic       wrStartQ,
  output logic       rdStartQ,
  output logic       memErase,
  output logic [1:0] memSpace
);

  logic       spaceCfgQ;
  logic       rowEraseQ;
  logic       errFlagQ;
  logic       wipQ;
  logic       opEraseQ;
  logic [1:0] opSpaceQ;
  logic       unusedWrBits;

  assign unusedWrBits = ^{regWrData[BIT_ZERO], regWrData[BIT_ERR],
                          regWrData[BIT_WR], regWrData[BIT_RD]};

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      spaceFlashQ <= 1'b0;
      spaceCfgQ   <= 1'b0;
      rowEraseQ   <= 1'b0;
      errFlagQ    <= 1'b0;
      wrEnableQ   <= 1'b0;
      wrStartQ    <= 1'b0;
      rdStartQ    <= 1'b0;
      wipQ        <= 1'b0;
      opEraseQ    <= 1'b0;
      opSpaceQ    <= 2'b00;
    end else if (!warmRstN) begin
      if (wipQ) errFlagQ <= 1'b1;
      wipQ      <= 1'b0;
      rowEraseQ <= 1'b0;
      wrEnableQ <= 1'b0;
      wrStartQ  <= 1'b0;
      rdStartQ  <= 1'b0;
    end else begin
      if (regWrEn) begin
        wrEnableQ <= regWrData[BIT_WREN];
        if (!strobe.lockSpace) begin
          spaceFlashQ <= regWrData[BIT_FLASH];
          spaceCfgQ   <= regWrData[BIT_CFG];
          rowEraseQ   <= regWrData[BIT_ERASE];
        end
      end
      if (strobe.setWr) begin
        wrStartQ <= 1'b1;
        wipQ     <= 1'b1;
        opEraseQ <= regWrData[BIT_ERASE];
        opSpaceQ <= regWrData[BIT_FLASH:BIT_CFG];
      end
      if (strobe.setRd) begin
        rdStartQ <= 1'b1;
      end else if (strobe.clrRd) begin
        rdStartQ <= 1'b0;
      end
      if (strobe.finish) begin
        wrStartQ <= 1'b0;
        wipQ     <= 1'b0;
        errFlagQ <= 1'b0;
        if (opEraseQ) rowEraseQ <= 1'b0;
      end
    end
  end

  assign regRdData = {spaceFlashQ, spaceCfgQ, 1'b0, rowEraseQ,
                      errFlagQ, wrEnableQ, wrStartQ, rdStartQ};
  assign memErase  = opEraseQ;
  assign memSpace  = opSpaceQ;

  // R5
  wr_needs_enable_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(wrStartQ) |-> $past(wrEnableQ));

  // R4
  rd_not_flash_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(rdStartQ) |-> !$past(spaceFlashQ));

  // R3
  rd_one_cycle_chk: assert property (@(posedge clk) disable iff (!porN)
    rdStartQ |=> !rdStartQ);

  // R10
  space_locked_chk: assert property (@(posedge clk) disable iff (!porN)
    wrStartQ |=> ($stable(spaceFlashQ) && $stable(spaceCfgQ)));

  // R7
  abort_flag_chk: assert property (@(posedge clk) disable iff (!porN)
    (!warmRstN && wipQ) |=> errFlagQ);

endmodule

// File: rtl/nvmCtrlReg.sv
module nvmCtrlReg
  import nvmCtrlPkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       warmRstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       readStrobe,
  output logic       memReq,
  output logic       memErase,
  output logic [1:0] memSpace,
  output logic       cycleDone
);

  nvmStrobe_t strobe;
  logic       spaceFlashQ;
  logic       wrEnableQ;
  logic       wrStartQ;
  logic       rdStartQ;
  logic       memDone;

  nvmCtrlRegfile regfile_i (
    .clk         (clk),
    .porN        (porN),
    .warmRstN    (warmRstN),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .strobe      (strobe),
    .regRdData   (regRdData),
    .spaceFlashQ (spaceFlashQ),
    .wrEnableQ   (wrEnableQ),
    .wrStartQ    (wrStartQ),
    .rdStartQ    (rdStartQ),
    .memErase    (memErase),
    .memSpace    (memSpace)
  );

  nvmCtrlSeq seq_i (
    .clk         (clk),
    .porN        (porN),
    .warmRstN    (warmRstN),
    .regWrEn     (regWrEn),
    .wrStartReq  (regWrData[BIT_WR]),
    .rdStartReq  (regWrData[BIT_RD]),
    .spaceFlashQ (spaceFlashQ),
    .wrEnableQ   (wrEnableQ),
    .wrStartQ    (wrStartQ),
    .rdStartQ    (rdStartQ),
    .memDone     (memDone),
    .strobe      (strobe),
    .memReq      (memReq),
    .cycleDone   (cycleDone)
  );

  nvmArrayModel #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) array_i (
    .clk      (clk),
    .porN     (porN),
    .warmRstN (warmRstN),
    .memReq   (memReq),
    .memDone  (memDone)
  );

  assign readStrobe = rdStartQ;

endmodule

// File: tb/nvmCtrlReg_tb.sv
`timescale 1ns/1ps
module nvmCtrlReg_tb_top;

  localparam int BUSY = 5;
  localparam int NVEC = 9;

  // {write data, expected register, expected readStrobe}
  localparam logic [16:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 1'b0},
    {8'h20, 8'h00, 1'b0},
    {8'h08, 8'h00, 1'b0},
    {8'h02, 8'h00, 1'b0},
    {8'h04, 8'h04, 1'b0},
    {8'h91, 8'h91, 1'b1},
    {8'h81, 8'h80, 1'b0},
    {8'h44, 8'h44, 1'b0},
    {8'h01, 8'h01, 1'b1}
  };
  localparam string VTAG [NVEC] = '{
    "R9", "R1", "R12", "R5", "R5", "R3", "R4", "R10", "R3"
  };

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic       warmRstN = 1'b1;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       readStrobe;
  logic       memReq;
  logic       memErase;
  logic [1:0] memSpace;
  logic       cycleDone;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  nvmCtrlReg #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk        (clk),
    .porN       (porN),
    .warmRstN   (warmRstN),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .readStrobe (readStrobe),
    .memReq     (memReq),
    .memErase   (memErase),
    .memSpace   (memSpace),
    .cycleDone  (cycleDone)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic doWrite(input logic [7:0] d);
    regWrEn   = 1'b1;
    regWrData = d;
    tick();
    regWrEn   = 1'b0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 40; k++) begin
      if (!regRdData[1]) break;
      tick();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int busyCnt;
    int reqCnt;
    int doneCnt;
    repeat (3) @(posedge clk);
    #2 porN = 1'b1;
    tick();

    // R9 reset state
    check("R9 reset reg", regRdData, 8'h00);
    check("R9 reset memReq", memReq, 1'b0);
    check("R11 reset cycleDone", cycleDone, 1'b0);

    // table walk: register access rules while idle
    for (int v = 0; v < NVEC; v++) begin
      doWrite(VEC[v][16:9]);
      check({VTAG[v], " table reg"}, regRdData, VEC[v][8:1]);
      check({VTAG[v], " table strobe"}, readStrobe, VEC[v][0]);
      check("R5 table memReq", memReq, 1'b0);
      tick();
    end
    check("R3 rd cleared", regRdData[0], 1'b0);

    // R2 R10 R13 plain write cycle
    doWrite(8'h84);
    doWrite(8'h86);
    check("R2 launch reg", regRdData, 8'h86);
    check("R13 launch memReq", memReq, 1'b1);
    check("R10 memSpace", memSpace, 2'b10);
    check("R6 write not erase", memErase, 1'b0);
    busyCnt = 1;
    reqCnt  = 1;
    for (int k = 1; k < 40; k++) begin
      regWrEn   = (k == 1);
      regWrData = 8'h45;
      tick();
      regWrEn = 1'b0;
      if (k == 1) check("R10 busy write ignored", regRdData, 8'h86);
      if (memReq) reqCnt++;
      if (!regRdData[1]) break;
      busyCnt++;
    end
    check("R2 busy length", busyCnt, BUSY);
    check("R13 memReq length", reqCnt, BUSY);
    check("R11 done pulse", cycleDone, 1'b1);
    check("R8 completion reg", regRdData, 8'h84);
    tick();
    check("R11 done one cycle", cycleDone, 1'b0);

    // R6 row erase
    doWrite(8'h94);
    doWrite(8'h96);
    check("R6 erase op", memErase, 1'b1);
    check("R6 erase reg", regRdData, 8'h96);
    waitIdle();
    check("R6 erase bit cleared", regRdData, 8'h84);
    tick();

    // R7 R11 warm reset abort
    doWrite(8'h44);
    doWrite(8'h46);
    tick();
    warmRstN = 1'b0;
    tick();
    warmRstN = 1'b1;
    check("R7 abort reg", regRdData, 8'h48);
    check("R7 abort memReq", memReq, 1'b0);
    doneCnt = 0;
    for (int k = 0; k < BUSY + 3; k++) begin
      if (cycleDone) doneCnt++;
      tick();
    end
    check("R11 no done after abort", doneCnt, 0);

    // R9 warm reset idle keeps flag and space bits
    warmRstN = 1'b0;
    tick();
    warmRstN = 1'b1;
    check("R9 warm idle", regRdData, 8'h48);

    // R12 software cannot clear the flag; R8 completion clears it
    doWrite(8'h40);
    check("R12 flag kept", regRdData, 8'h48);
    doWrite(8'h44);
    check("R12 flag with enable", regRdData, 8'h4C);
    doWrite(8'h46);
    waitIdle();
    check("R8 flag cleared", regRdData, 8'h44);

    // R9 asynchronous power-on reset
    doWrite(8'hC4);
    #1 porN = 1'b0;
    #1;
    check("R9 async por", regRdData, 8'h00);
    tick();
    porN = 1'b1;
    tick();
    check("R9 after por", regRdData, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule